// File: doc/BRIEF.md
# Synthesizer Divider and Phase Detector Core

This block is the digital heart of a frequency-synthesis loop. A reference divider turns the crystal clock into a low comparison frequency. A programmable divider turns the prescaled oscillator clock into a signal that should match it. A phase-frequency detector compares the falling edges of the two divided signals and produces pump-up and pump-down requests for an external charge pump. The block also passes the pump current range and the filter-output disable to the analog side. A test route can replace two general-purpose port bits with the two divided signals.

The block runs on one system clock. The crystal and the prescaled oscillator each arrive as a single-cycle tick strobe that is synchronous to that clock, so every phase difference is measured in whole system-clock cycles. With the default parameters the reference divides by 512. The oscillator ratio is a 15-bit word with a floor of 256. The ratio and the control bits come from a separate register block.

Top module: `synth_core`

## Requirements
- R1: After reset the divided reference is high. It goes low on the REF_DIV/2-th crystal tick and high again on the REF_DIV-th tick, and then repeats with a period of REF_DIV ticks (512 by default).
- R2: The divided oscillator signal has a period of exactly N oscillator ticks, where N is the unsigned binary value of `ratio`. In each period it is high for the first floor(N/2) ticks counted from the start of the period and low for the rest. The period that starts at reset uses N_MIN.
- R3: A new `ratio` value takes effect only when the current divided-oscillator period completes. A change in the middle of a period does not alter the length of that period.
- R4: A `ratio` below N_MIN (256 by default) is treated as N_MIN.
- R5: If the divided oscillator falls d cycles before the divided reference, `pumpUp` is high from the cycle after the oscillator edge until the cycle after the reference edge, and `pumpDrive` is high for exactly d cycles. The reverse order drives `pumpDn` in the same way.
- R6: Once both detector requests are set, both clear on the next cycle. When the two falling edges coincide, `pumpUp` and `pumpDn` are each high for one cycle and `pumpDrive` stays low.
- R7: While `tristate` is 1, `pumpUp`, `pumpDn` and `pumpDrive` are all 0 in the same cycle. The detector keeps its state, and that state shows again once `tristate` returns to 0.
- R8: With `testRoute` = 1, `auxPortOut[0]` carries the divided reference and `auxPortOut[1]` carries the divided oscillator signal. With `testRoute` = 0, `auxPortOut` equals `auxPortBits`.
- R9: `pumpHiRange` follows `hiCurrent`, and `filterDisable` follows `filterOff`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| xtalTick | input | 1 | One-cycle strobe per crystal period |
| vcoTick | input | 1 | One-cycle strobe per prescaled oscillator period |
| ratio | input | N_WIDTH | Programmable divider ratio (15 bits by default) |
| tristate | input | 1 | Forces all pump outputs off |
| hiCurrent | input | 1 | Selects the high pump-current range |
| filterOff | input | 1 | Requests that the filter output be disconnected |
| testRoute | input | 1 | Routes the divided signals to the two port bits |
| auxPortBits | input | 2 | Register values for the two shared port bits |
| pumpUp | output | 1 | Pump-up request |
| pumpDn | output | 1 | Pump-down request |
| pumpDrive | output | 1 | Pump output enable: exactly one request is active |
| pumpHiRange | output | 1 | High pump-current range select |
| filterDisable | output | 1 | Filter-output disable |
| auxPortOut | output | 2 | Shared port bits after the test route |

## Verification
The hardest situation to reach from the ports is two falling edges landing in the same cycle while the detector is idle. Without that, the one-cycle overlap rule of R6 is never exercised in its pure form. The bench reaches it by giving the oscillator divider a fixed number of solo ticks and then ticking both dividers together, which places the edges of both dividers in one cycle a known number of periods later. A ratio change in the middle of a period is the second hard case. It is applied at a known count, and the bench then measures the lengths of the current and the following periods on the routed test port.

// File: rtl/synth_pkg.sv
package synth_pkg;

  // Strobes and levels handed from the divider control to the detector datapath.
  typedef struct packed {
    logic refFall;   // divided reference falls on this edge
    logic vcoFall;   // divided oscillator falls on this edge
    logic refLevel;  // registered divided reference
    logic vcoLevel;  // registered divided oscillator
  } div_strobe_t;

endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import synth_pkg::*;
#(
  parameter int REF_DIV = 512,
  parameter int N_WIDTH = 15,
  parameter int N_MIN   = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               xtalTick,
  input  logic               vcoTick,
  input  logic [N_WIDTH-1:0] ratio,
  output div_strobe_t        strb
);

  localparam int REF_W    = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;
  localparam int REF_HALF = REF_DIV / 2;
  localparam logic [N_WIDTH-1:0] N_FLOOR = N_WIDTH'(N_MIN);

  // Reference divider
  logic [REF_W-1:0] refCnt;
  logic [REF_W-1:0] refNext;
  logic             refLvl;

  generate
    if (REF_DIV == (1 << REF_W)) begin : g_refPow2
      assign refNext = refCnt + REF_W'(1);
    end else begin : g_refMod
      assign refNext = (refCnt == REF_W'(REF_DIV - 1)) ? '0 : refCnt + REF_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt <= '0;
      refLvl <= 1'b1;
    end else if (xtalTick) begin
      refCnt <= refNext;
      refLvl <= (refNext < REF_W'(REF_HALF));
    end
  end

  // Programmable divider; ratio taken only at terminal count
  logic [N_WIDTH-1:0] vcoCnt;
  logic [N_WIDTH-1:0] activeN;
  logic [N_WIDTH-1:0] ratioEff;
  logic [N_WIDTH-1:0] vcoNext;
  logic [N_WIDTH-1:0] nNext;
  logic               vcoWrap;
  logic               vcoLvl;

  always_comb begin
    ratioEff = (ratio < N_FLOOR) ? N_FLOOR : ratio;
    vcoWrap  = (vcoCnt == activeN - N_WIDTH'(1));
    vcoNext  = vcoWrap ? '0 : vcoCnt + N_WIDTH'(1);
    nNext    = vcoWrap ? ratioEff : activeN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vcoCnt  <= '0;
      activeN <= N_FLOOR;
      vcoLvl  <= 1'b1;
    end else if (vcoTick) begin
      vcoCnt  <= vcoNext;
      activeN <= nNext;
      vcoLvl  <= (vcoNext < (nNext >> 1));
    end
  end

  always_comb begin
    strb.refFall  = xtalTick && (refCnt == REF_W'(REF_HALF - 1));
    strb.vcoFall  = vcoTick && !vcoWrap && ((vcoCnt + N_WIDTH'(1)) == (activeN >> 1));
    strb.refLevel = refLvl;
    strb.vcoLevel = vcoLvl;
  end

endmodule

// File: rtl/sdiv_dpath.sv
module sdiv_dpath
  import synth_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  div_strobe_t strb,
  input  logic        tristate,
  input  logic        hiCurrent,
  input  logic        filterOff,
  input  logic        testRoute,
  input  logic [1:0]  auxPortBits,
  output logic        pumpUp,
  output logic        pumpDn,
  output logic        pumpDrive,
  output logic        pumpHiRange,
  output logic        filterDisable,
  output logic [1:0]  auxPortOut,
  output logic        pfdUp,
  output logic        pfdDn
);

  localparam int LANES = 2;

  logic upQ;
  logic dnQ;

  // Detector: set on falling edges, cleared one cycle after both are set.
  // An edge landing in the clearing cycle is kept, not lost.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else if (upQ && dnQ) begin
      upQ <= strb.vcoFall;
      dnQ <= strb.refFall;
    end else begin
      upQ <= upQ | strb.vcoFall;
      dnQ <= dnQ | strb.refFall;
    end
  end

  assign pfdUp = upQ;
  assign pfdDn = dnQ;

  always_comb begin
    pumpUp        = upQ & ~tristate;
    pumpDn        = dnQ & ~tristate;
    pumpDrive     = (upQ ^ dnQ) & ~tristate;
    pumpHiRange   = hiCurrent;
    filterDisable = filterOff;
  end

  // Test route: lane 0 takes the reference, lane 1 the oscillator
  logic [LANES-1:0] routed;
  assign routed = {strb.vcoLevel, strb.refLevel};

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign auxPortOut[g] = testRoute ? routed[g] : auxPortBits[g];
    end
  endgenerate

endmodule

// File: rtl/synth_core.sv
module synth_core
  import synth_pkg::*;
#(
  parameter int REF_DIV = 512,
  parameter int N_WIDTH = 15,
  parameter int N_MIN   = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               xtalTick,
  input  logic               vcoTick,
  input  logic [N_WIDTH-1:0] ratio,
  input  logic               tristate,
  input  logic               hiCurrent,
  input  logic               filterOff,
  input  logic               testRoute,
  input  logic [1:0]         auxPortBits,
  output logic               pumpUp,
  output logic               pumpDn,
  output logic               pumpDrive,
  output logic               pumpHiRange,
  output logic               filterDisable,
  output logic [1:0]         auxPortOut
);

  div_strobe_t strb;
  logic        pfdUp;
  logic        pfdDn;

  sdiv_ctrl #(
    .REF_DIV(REF_DIV),
    .N_WIDTH(N_WIDTH),
    .N_MIN  (N_MIN)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .xtalTick(xtalTick),
    .vcoTick (vcoTick),
    .ratio   (ratio),
    .strb    (strb)
  );

  sdiv_dpath u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .tristate     (tristate),
    .hiCurrent    (hiCurrent),
    .filterOff    (filterOff),
    .testRoute    (testRoute),
    .auxPortBits  (auxPortBits),
    .pumpUp       (pumpUp),
    .pumpDn       (pumpDn),
    .pumpDrive    (pumpDrive),
    .pumpHiRange  (pumpHiRange),
    .filterDisable(filterDisable),
    .auxPortOut   (auxPortOut),
    .pfdUp        (pfdUp),
    .pfdDn        (pfdDn)
  );

endmodule

// File: rtl/synth_core_chk.sv
module synth_core_chk
  import synth_pkg::*;
#(
  parameter int REF_DIV = 512,
  parameter int N_MIN   = 256
) (
  input logic        clk,
  input logic        rstN,
  input logic        xtalTick,
  input logic        vcoTick,
  input logic        tristate,
  input logic        testRoute,
  input logic [1:0]  auxPortOut,
  input logic        pumpUp,
  input logic        pumpDn,
  input logic        pumpDrive,
  input div_strobe_t strb,
  input logic        pfdUp,
  input logic        pfdDn
);

  logic [31:0] refTicks;
  logic [31:0] vcoTicks;
  logic        refPrimed;
  logic        vcoPrimed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refTicks  <= '0;
      vcoTicks  <= '0;
      refPrimed <= 1'b0;
      vcoPrimed <= 1'b0;
    end else begin
      if (xtalTick) refTicks <= strb.refFall ? 32'd0 : refTicks + 32'd1;
      if (vcoTick)  vcoTicks <= strb.vcoFall ? 32'd0 : vcoTicks + 32'd1;
      if (strb.refFall) refPrimed <= 1'b1;
      if (strb.vcoFall) vcoPrimed <= 1'b1;
    end
  end

  // R1: consecutive reference falls are REF_DIV crystal ticks apart
  assert_ref_period_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.refFall && refPrimed) |-> (refTicks == 32'(REF_DIV - 1)));

  // R4: the clamp keeps oscillator falls at least N_MIN ticks apart
  assert_vco_floor_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.vcoFall && vcoPrimed) |-> (vcoTicks >= 32'(N_MIN - 1)));

  // R5: each falling edge sets its detector request on the next cycle
  assert_up_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.vcoFall |=> pfdUp);
  assert_dn_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.refFall |=> pfdDn);

  // R6: both requests never stay set together for two cycles
  assert_min_reset_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pfdUp && pfdDn) |=> !(pfdUp && pfdDn));

  // R7: tristate silences every pump output
  assert_hiz_R7: assert property (@(posedge clk) disable iff (!rstN)
    tristate |-> (!pumpUp && !pumpDn && !pumpDrive));

  // R8: test route shows the divided levels
  assert_route_R8: assert property (@(posedge clk) disable iff (!rstN)
    testRoute |-> (auxPortOut == {strb.vcoLevel, strb.refLevel}));

endmodule

bind synth_core synth_core_chk #(
  .REF_DIV(REF_DIV),
  .N_MIN  (N_MIN)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .xtalTick  (xtalTick),
  .vcoTick   (vcoTick),
  .tristate  (tristate),
  .testRoute (testRoute),
  .auxPortOut(auxPortOut),
  .pumpUp    (pumpUp),
  .pumpDn    (pumpDn),
  .pumpDrive (pumpDrive),
  .strb      (strb),
  .pfdUp     (pfdUp),
  .pfdDn     (pfdDn)
);

// File: tb/synth_core_test.sv
`timescale 1ns/1ps
module synth_core_test;

  localparam int RDIV  = 8;
  localparam int NW    = 6;
  localparam int NMIN  = 4;
  localparam int RHALF = RDIV / 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          xtalTick = 1'b0;
  logic          vcoTick = 1'b0;
  logic [NW-1:0] ratio = '0;
  logic          tristate = 1'b0;
  logic          hiCurrent = 1'b0;
  logic          filterOff = 1'b0;
  logic          testRoute = 1'b1;
  logic [1:0]    auxPortBits = 2'b00;
  logic          pumpUp, pumpDn, pumpDrive, pumpHiRange, filterDisable;
  logic [1:0]    auxPortOut;

  synth_core #(.REF_DIV(RDIV), .N_WIDTH(NW), .N_MIN(NMIN)) uut (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .vcoTick(vcoTick),
    .ratio(ratio), .tristate(tristate), .hiCurrent(hiCurrent),
    .filterOff(filterOff), .testRoute(testRoute), .auxPortBits(auxPortBits),
    .pumpUp(pumpUp), .pumpDn(pumpDn), .pumpDrive(pumpDrive),
    .pumpHiRange(pumpHiRange), .filterDisable(filterDisable),
    .auxPortOut(auxPortOut)
  );

  always #2 clk = ~clk;

  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;
  string vTag = "R2";

  // Bench model state
  int rk, vk, mN;
  bit mu, md;

  function automatic int clampN(input int r);
    return (r < NMIN) ? NMIN : r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    rk = 0; vk = 0; mN = NMIN; mu = 0; md = 0;
  endtask

  task automatic doReset();
    xtalTick = 1'b0; vcoTick = 1'b0; rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    modelReset();
  endtask

  task automatic cycleStep(input bit xt, input bit vt);
    bit oldRl, oldVl, rf, vf, rl, vl;
    xtalTick = xt; vcoTick = vt;
    @(posedge clk);
    oldRl = (rk < RHALF);
    oldVl = (vk < mN / 2);
    if (xt) rk = (rk + 1) % RDIV;
    if (vt) begin
      if (vk == mN - 1) begin vk = 0; mN = clampN(int'(ratio)); end
      else vk++;
    end
    rl = (rk < RHALF);
    vl = (vk < mN / 2);
    rf = oldRl && !rl;
    vf = oldVl && !vl;
    if (mu && md) begin mu = vf; md = rf; end
    else begin mu = mu | vf; md = md | rf; end
    #1;
    if (testRoute) begin
      check("R1 ref level", int'(auxPortOut[0]), int'(rl));
      check({vTag, " vco level"}, int'(auxPortOut[1]), int'(vl));
    end else begin
      check("R8 port passthrough", int'(auxPortOut), int'(auxPortBits));
    end
    check(tristate ? "R7 up" : "R5 up", int'(pumpUp), int'(mu & !tristate));
    check(tristate ? "R7 dn" : "R5 dn", int'(pumpDn), int'(md & !tristate));
    check(tristate ? "R7 drive" : "R5 drive", int'(pumpDrive), int'((mu ^ md) & !tristate));
    check("R9 range", int'(pumpHiRange), int'(hiCurrent));
    check("R9 filter", int'(filterDisable), int'(filterOff));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int driveCnt, bothCnt, cnt;
    bit prev, seen;

    // Reset state
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    check("R1 reset ref level", int'(auxPortOut[0]), 1);
    check("R2 reset vco level", int'(auxPortOut[1]), 1);
    check("R5 reset pumps", int'({pumpUp, pumpDn, pumpDrive}), 0);

    // R5: oscillator edge 4 cycles ahead of the reference edge
    doReset(); ratio = 6'd8; vTag = "R2";
    driveCnt = 0;
    repeat (2) begin cycleStep(0, 1); driveCnt += int'(pumpDrive); end
    repeat (4) begin cycleStep(1, 0); driveCnt += int'(pumpDrive); end
    repeat (3) begin cycleStep(0, 0); driveCnt += int'(pumpDrive); end
    check("R5 drive length for d=4", driveCnt, 4);

    // R5 reverse order: reference first, down request
    doReset(); ratio = 6'd8;
    driveCnt = 0; bothCnt = 0;
    repeat (4) begin cycleStep(1, 0); driveCnt += int'(pumpDrive); bothCnt += int'(pumpDn); end
    repeat (3) begin cycleStep(0, 0); driveCnt += int'(pumpDrive); bothCnt += int'(pumpDn); end
    cycleStep(0, 1); driveCnt += int'(pumpDrive); bothCnt += int'(pumpDn);
    cycleStep(0, 1); driveCnt += int'(pumpDrive); bothCnt += int'(pumpDn);
    cycleStep(0, 0);
    check("R5 reverse drive length", driveCnt, 5);
    check("R5 reverse dn length", bothCnt, 6);

    // R6: coincident falls while the detector is idle
    doReset(); ratio = 6'd8;
    repeat (4) cycleStep(0, 1);
    driveCnt = 0; bothCnt = 0;
    for (int j = 1; j <= 14; j++) begin
      cycleStep(1, 1);
      if (j >= 11) begin
        driveCnt += int'(pumpDrive);
        bothCnt  += int'(pumpUp && pumpDn);
      end
    end
    check("R6 coincident drive cycles", driveCnt, 0);
    check("R6 coincident overlap cycles", bothCnt, 1);

    // R7: tristate hides but keeps the detector state
    doReset(); ratio = 6'd8;
    repeat (2) cycleStep(0, 1);
    tristate = 1'b1; #1;
    check("R7 up hidden", int'(pumpUp), 0);
    check("R7 drive hidden", int'(pumpDrive), 0);
    cycleStep(0, 0);
    tristate = 1'b0; #1;
    check("R7 up restored", int'(pumpUp), 1);
    check("R7 drive restored", int'(pumpDrive), 1);

    // R3: ratio change mid-period
    doReset(); ratio = 6'd10; vTag = "R3";
    repeat (7) cycleStep(0, 1);
    ratio = 6'd6;
    cnt = 0; seen = 0; prev = auxPortOut[1];
    for (int i = 0; i < 20; i++) begin
      if (!seen) begin
        cycleStep(0, 1); cnt++;
        if (!prev && auxPortOut[1]) seen = 1;
        prev = auxPortOut[1];
      end
    end
    check("R3 current period finishes at old ratio", cnt, 7);
    cnt = 0; seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (!seen) begin
        cycleStep(0, 1); cnt++;
        if (!prev && auxPortOut[1]) seen = 1;
        prev = auxPortOut[1];
      end
    end
    check("R3 next period uses new ratio", cnt, 6);

    // R4 directed: ratio 1 clamps to NMIN
    doReset(); ratio = 6'd1; vTag = "R4";
    repeat (4) cycleStep(0, 1);
    cnt = 0; seen = 0; prev = auxPortOut[1];
    for (int i = 0; i < 20; i++) begin
      if (!seen) begin
        cycleStep(0, 1); cnt++;
        if (!prev && auxPortOut[1]) seen = 1;
        prev = auxPortOut[1];
      end
    end
    check("R4 clamped period", cnt, NMIN);

    // Sweep over ratios with mixed tick patterns and control bits
    for (int i = 0; i < 16; i++) begin
      int r, steps;
      r = (i < 15) ? i : 63;
      doReset();
      ratio = NW'(r);
      vTag = (r < NMIN) ? "R4" : "R2";
      steps = 3 * clampN(r) + 3 * RDIV + 8;
      for (int c = 0; c < steps; c++) begin
        tristate    = ((c % 7) == 5);
        testRoute   = ((c % 5) != 2);
        auxPortBits = 2'(c);
        hiCurrent   = ((c % 3) == 0);
        filterOff   = ((c % 4) < 2);
        cycleStep(((c + i) % 3) != 1, (c % 4) != 3);
      end
    end
    tristate = 1'b0; testRoute = 1'b1;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule